// File: doc/BRIEF.md
# Framed Manchester Line Transmitter

This block serialises one 8-bit character at a time onto a single output line using Manchester coding. A character enters over a valid/ready handshake. Once accepted, the block sends a training preamble of selectable pattern and length, then a start delimiter, then the eight data bits, least significant bit first. After the character the line returns to its idle high level.

Timing comes from an external half-bit strobe (`half_tick`). Each strobe moves the line on by one half-bit, so one coded bit spans two strobes. The configuration inputs set the preamble pattern and length, the coding polarity and the delimiter style. The block samples them in the cycle it accepts a character, and they may change freely while that character is being sent.

Top module: `mcode_tx`

## Requirements
- R1: While `rst` is high, and in the cycle after it has been high, `line_o` is 1 and `in_ready` is 1. A reset in the middle of a character abandons that character.
- R2: A character is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle on. It returns to 1 in the same cycle that the line returns to 1 after the last data half-bit.
- R3: `line_o` changes only in the cycle after an edge where `half_tick` is 1. A strobe in the acceptance cycle is ignored. The first half-bit is driven at the first strobe after that cycle, and each later strobe drives the next half-bit.
- R4: A character goes out as the preamble, then the delimiter, then data bits 0 to 7, then one extra half-bit period that restores the idle level.
- R5: With `cfg_pol_inv`=0, a bit of value 0 is sent low then high, and a bit of value 1 is sent high then low. Data bits, preamble bits and the one-bit delimiter all follow this rule.
- R6: With `cfg_pol_inv`=1, every coded bit uses the opposite half-bit levels from R5.
- R7: `cfg_pre_len` gives the preamble length, from 0 to 15 bit times. A value of 0 means the delimiter follows the acceptance with no preamble.
- R8: `cfg_pre_pat` selects the value of preamble bit i, counting from i=0: 2'b00 gives all ones and 2'b01 gives all zeros. 2'b10 gives one for even i and zero for odd i. 2'b11 gives zero for even i and one for odd i.
- R9: With `cfg_sync_sfd`=0, the delimiter is one coded bit of value 0.
- R10: With `cfg_sync_sfd`=1, the delimiter is six half-bits. The first three are at level 1 when `cfg_pol_inv`=0, or at level 0 when `cfg_pol_inv`=1. The last three are at the opposite level.
- R11: Data and configuration are sampled at acceptance. Changing them afterwards has no effect on the character being sent.
- R12: While no character is in progress, a `half_tick` strobe leaves `line_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can take a character |
| in_data | input | 8 | Character to send |
| cfg_pre_len | input | 4 | Preamble length in bit times |
| cfg_pre_pat | input | 2 | Preamble pattern select |
| cfg_pol_inv | input | 1 | Inverts the coding polarity |
| cfg_sync_sfd | input | 1 | 1 = three-bit-time sync delimiter, 0 = one-bit delimiter |
| half_tick | input | 1 | Half-bit strobe |
| line_o | output | 1 | Serial line, registered |

## Verification
Acceptance of a new character and a half-bit strobe can fall on the same clock edge. The strobe must then be ignored, so that the first preamble half-bit waits for the next strobe. The bench provokes this by varying the strobe period from every cycle to every fourth cycle while offering characters at varying offsets. Every strobe that lands on an acceptance edge is judged by checking that the line stays high, and that the next half-bit seen on the line is the first expected one. A second meeting happens when the final restoring strobe arrives while a new character is already waiting. There the bench checks that `in_ready` only rises with the idle level, and that the waiting character is taken one edge later.

// File: rtl/mcode_tx_pkg.sv
package mcode_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SFD,
    PH_DATA,
    PH_TAIL
  } phase_t;

  typedef enum logic [1:0] {
    PAT_ONES       = 2'b00,
    PAT_ZEROS      = 2'b01,
    PAT_ONE_FIRST  = 2'b10,
    PAT_ZERO_FIRST = 2'b11
  } pre_pat_t;

  // Level of one half of a coded bit; default polarity sends a one high-first.
  function automatic logic manch_half(input logic bit_v, input logic pol_inv,
                                      input logic second);
    return bit_v ^ pol_inv ^ second;
  endfunction

endpackage

// File: rtl/mcode_tx_seq.sv
module mcode_tx_seq
  import mcode_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LEN_W-1:0]  cfg_pre_len,
  input  logic [1:0]        cfg_pre_pat,
  input  logic              cfg_pol_inv,
  input  logic              cfg_sync_sfd,
  input  logic              half_tick,
  output phase_t            phase_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              half_o,
  output logic              step_o,
  output logic [DATA_W-1:0] data_o,
  output pre_pat_t          pat_o,
  output logic              pol_o,
  output logic              sync_o
);

  phase_t             phase_q;
  logic [IDX_W-1:0]   idx_q;
  logic               half_q;
  logic [DATA_W-1:0]  data_q;
  logic [LEN_W-1:0]   len_q;
  pre_pat_t           pat_q;
  logic               pol_q;
  logic               sync_q;

  logic               accept;
  logic               step;
  logic [IDX_W-1:0]   last_idx;
  phase_t             next_phase;

  assign in_ready = (phase_q == PH_IDLE);
  assign accept   = in_valid && in_ready;
  assign step     = half_tick && (phase_q != PH_IDLE);

  always_comb begin
    last_idx   = '0;
    next_phase = PH_IDLE;
    case (phase_q)
      PH_PRE: begin
        last_idx   = IDX_W'(len_q) - IDX_W'(1);
        next_phase = PH_SFD;
      end
      PH_SFD: begin
        last_idx   = sync_q ? IDX_W'(2) : IDX_W'(0);
        next_phase = PH_DATA;
      end
      PH_DATA: begin
        last_idx   = IDX_W'(DATA_W - 1);
        next_phase = PH_TAIL;
      end
      default: begin
        last_idx   = '0;
        next_phase = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      half_q  <= 1'b0;
      data_q  <= '0;
      len_q   <= '0;
      pat_q   <= PAT_ONES;
      pol_q   <= 1'b0;
      sync_q  <= 1'b0;
    end else if (accept) begin
      phase_q <= (cfg_pre_len != '0) ? PH_PRE : PH_SFD;
      idx_q   <= '0;
      half_q  <= 1'b0;
      data_q  <= in_data;
      len_q   <= cfg_pre_len;
      pat_q   <= pre_pat_t'(cfg_pre_pat);
      pol_q   <= cfg_pol_inv;
      sync_q  <= cfg_sync_sfd;
    end else if (step) begin
      if (phase_q == PH_TAIL) begin
        phase_q <= PH_IDLE;
      end else if (!half_q) begin
        half_q <= 1'b1;
      end else begin
        half_q <= 1'b0;
        if (idx_q == last_idx) begin
          idx_q   <= '0;
          phase_q <= next_phase;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign half_o  = half_q;
  assign step_o  = step;
  assign data_o  = data_q;
  assign pat_o   = pat_q;
  assign pol_o   = pol_q;
  assign sync_o  = sync_q;

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);

  assert_skip_preamble_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && cfg_pre_len == '0) |=> (phase_q == PH_SFD));

  assert_enter_preamble_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && cfg_pre_len != '0) |=> (phase_q == PH_PRE));

  assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (!half_tick && !accept) |=> ($stable(phase_q) && $stable(idx_q) && $stable(half_q)));

endmodule

// File: rtl/mcode_tx_level.sv
module mcode_tx_level
  import mcode_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  phase_t            phase_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              half_i,
  input  logic [DATA_W-1:0] data_i,
  input  pre_pat_t          pat_i,
  input  logic              pol_i,
  input  logic              sync_i,
  output logic              level_o
);

  localparam int DSEL_W = $clog2(DATA_W);

  logic bit_v;
  logic sync_first;

  // Sync delimiter: half-bits 0..2 at the lead level, 3..5 at the other.
  assign sync_first = (idx_i == IDX_W'(0)) || ((idx_i == IDX_W'(1)) && !half_i);

  always_comb begin
    bit_v = 1'b1;
    case (pat_i)
      PAT_ONES:       bit_v = 1'b1;
      PAT_ZEROS:      bit_v = 1'b0;
      PAT_ONE_FIRST:  bit_v = ~idx_i[0];
      PAT_ZERO_FIRST: bit_v = idx_i[0];
      default:        bit_v = 1'b1;
    endcase
    if (phase_i == PH_SFD) bit_v = 1'b0;
    if (phase_i == PH_DATA) bit_v = data_i[idx_i[DSEL_W-1:0]];
  end

  always_comb begin
    case (phase_i)
      PH_PRE, PH_DATA: level_o = manch_half(bit_v, pol_i, half_i);
      PH_SFD:          level_o = sync_i ? (sync_first ^ pol_i)
                                        : manch_half(bit_v, pol_i, half_i);
      default:         level_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/mcode_tx.sv
module mcode_tx
  import mcode_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LEN_W-1:0]  cfg_pre_len,
  input  logic [1:0]        cfg_pre_pat,
  input  logic              cfg_pol_inv,
  input  logic              cfg_sync_sfd,
  input  logic              half_tick,
  output logic              line_o
);

  localparam int DSEL_W = $clog2(DATA_W);
  localparam int IDX_W  = (LEN_W > DSEL_W) ? LEN_W : DSEL_W;

  phase_t             phase;
  logic [IDX_W-1:0]   idx;
  logic               half;
  logic               step;
  logic [DATA_W-1:0]  data_q;
  pre_pat_t           pat_q;
  logic               pol_q;
  logic               sync_q;
  logic               level;
  logic               line_q;

  mcode_tx_seq #(
    .DATA_W(DATA_W),
    .LEN_W (LEN_W),
    .IDX_W (IDX_W)
  ) seq_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .cfg_pre_len (cfg_pre_len),
    .cfg_pre_pat (cfg_pre_pat),
    .cfg_pol_inv (cfg_pol_inv),
    .cfg_sync_sfd(cfg_sync_sfd),
    .half_tick   (half_tick),
    .phase_o     (phase),
    .idx_o       (idx),
    .half_o      (half),
    .step_o      (step),
    .data_o      (data_q),
    .pat_o       (pat_q),
    .pol_o       (pol_q),
    .sync_o      (sync_q)
  );

  mcode_tx_level #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) level_i (
    .phase_i(phase),
    .idx_i  (idx),
    .half_i (half),
    .data_i (data_q),
    .pat_i  (pat_q),
    .pol_i  (pol_q),
    .sync_i (sync_q),
    .level_o(level)
  );

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b1;
    else if (step) line_q <= level;
  end

  assign line_o = line_q;

  assert_idle_high_R12: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> line_o);

  assert_line_moves_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    !half_tick |=> $stable(line_o));

  assert_mid_bit_flip_R5: assert property (@(posedge clk) disable iff (rst)
    (step && phase == PH_DATA && half) |-> (level != line_o));

  assert_sync_no_flip_R10: assert property (@(posedge clk) disable iff (rst)
    (step && phase == PH_SFD && sync_q && idx == IDX_W'(1) && !half) |-> (level == line_o));

endmodule

// File: tb/mcode_tx_tb_top.sv
`timescale 1ns/1ps
module mcode_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic [3:0] cfg_pre_len = 4'd0;
  logic [1:0] cfg_pre_pat = 2'b00;
  logic       cfg_pol_inv = 1'b0;
  logic       cfg_sync_sfd = 1'b0;
  logic       half_tick = 1'b0;
  logic       line_o;

  always #2.5 clk = ~clk;

  mcode_tx dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_pre_len(cfg_pre_len), .cfg_pre_pat(cfg_pre_pat),
    .cfg_pol_inv(cfg_pol_inv), .cfg_sync_sfd(cfg_sync_sfd),
    .half_tick(half_tick), .line_o(line_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_tag = "R4";
  logic [1:0] exp_q[$];   // bit0 expected level, bit1 marks the restoring half
  bit    active = 0;
  logic  tick_edge = 1'b0;
  logic  acc_edge = 1'b0;
  int    tdiv = 3;
  int    tcnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Half-bit strobe generator
  always @(negedge clk) begin
    if (tcnt + 1 >= tdiv) begin
      tcnt = 0;
      half_tick <= 1'b1;
    end else begin
      tcnt++;
      half_tick <= 1'b0;
    end
  end

  always @(posedge clk) begin
    tick_edge <= half_tick;
    acc_edge  <= in_valid && in_ready && !rst;
  end

  // Monitor: pops one expected half-bit per strobe edge
  always @(negedge clk) begin
    if (!rst) begin
      if (acc_edge) begin
        active = 1;
        check(line_o == 1'b1, "R3 line held at acceptance edge", line_o, 1);
        check(in_ready == 1'b0, "R2 ready low after acceptance", in_ready, 0);
      end else if (tick_edge) begin
        if (active) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected half-bit", line_o, -1);
            active = 0;
          end else begin
            logic [1:0] e;
            e = exp_q.pop_front();
            check(line_o == e[0], cur_tag, line_o, e[0]);
            if (e[1]) begin
              active = 0;
              check(in_ready == 1'b1, "R2 ready back with idle level", in_ready, 1);
            end else begin
              check(in_ready == 1'b0, "R2 ready low during character", in_ready, 0);
            end
          end
        end else begin
          check(line_o == 1'b1, "R12 idle strobe keeps line high", line_o, 1);
        end
      end
    end
  end

  task automatic push_bit(input logic b, input logic pol);
    exp_q.push_back({1'b0, b ^ pol});
    exp_q.push_back({1'b0, ~(b ^ pol)});
  endtask

  task automatic send(input logic [7:0] d, input int len, input logic [1:0] pat,
                      input logic pol, input logic sync, input int lead, input string tag);
    repeat (lead) @(negedge clk);
    do @(negedge clk); while (!in_ready);
    cur_tag = tag;
    for (int i = 0; i < len; i++) begin
      logic b;
      case (pat)
        2'b00: b = 1'b1;
        2'b01: b = 1'b0;
        2'b10: b = (i % 2 == 0);
        default: b = (i % 2 == 1);
      endcase
      push_bit(b, pol);
    end
    if (sync) begin
      for (int k = 0; k < 6; k++) exp_q.push_back({1'b0, (k < 3) ? ~pol : pol});
    end else begin
      push_bit(1'b0, pol);
    end
    for (int k = 0; k < 8; k++) push_bit(d[k], pol);
    exp_q.push_back(2'b11);
    in_data      = d;
    cfg_pre_len  = 4'(len);
    cfg_pre_pat  = pat;
    cfg_pol_inv  = pol;
    cfg_sync_sfd = sync;
    in_valid     = 1'b1;
    @(negedge clk);
    in_valid     = 1'b0;
    // R11: scramble inputs after acceptance
    in_data      = ~d;
    cfg_pre_len  = ~cfg_pre_len;
    cfg_pre_pat  = ~pat;
    cfg_pol_inv  = ~pol;
    cfg_sync_sfd = ~sync;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() != 0 || active || !in_ready);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(line_o == 1'b1, "R1 line high in reset", line_o, 1);
    check(in_ready == 1'b1, "R1 ready high in reset", in_ready, 1);
    rst = 1'b0;
    repeat (6) @(negedge clk);

    send(8'hA5, 4, 2'b00, 1'b0, 1'b0, 0, "R5 R9 R11 default coding");
    send(8'h3C, 0, 2'b01, 1'b0, 1'b0, 1, "R7 no preamble");
    send(8'hC3, 15, 2'b10, 1'b0, 1'b0, 2, "R8 R7 one-first preamble, length 15");
    send(8'h5A, 5, 2'b11, 1'b1, 1'b0, 0, "R6 R8 inverted polarity zero-first");
    send(8'hF0, 2, 2'b10, 1'b0, 1'b1, 3, "R10 sync delimiter");
    send(8'h0F, 0, 2'b00, 1'b1, 1'b1, 0, "R10 R6 sync delimiter inverted");
    send(8'h80, 1, 2'b01, 1'b1, 1'b0, 1, "R8 R4 all-zero preamble, length 1");
    wait_idle();

    tdiv = 1;
    send(8'h01, 3, 2'b11, 1'b0, 1'b0, 0, "R3 strobe every cycle");
    send(8'hFE, 0, 2'b00, 1'b0, 1'b1, 0, "R3 R10 strobe every cycle sync");
    wait_idle();
    for (int p = 2; p <= 4; p++) begin
      tdiv = p;
      for (int off = 0; off < 4; off++)
        send(8'(8'h11 * (off + p)), off + 1, 2'(off), 1'(off), 1'(p), off,
             "R3 R4 strobe/acceptance offsets");
      wait_idle();
    end

    tdiv = 3;
    send(8'h96, 6, 2'b10, 1'b0, 1'b0, 0, "R1 frame cut by reset");
    repeat (25) @(negedge clk);
    rst = 1'b1;
    exp_q.delete();
    active = 0;
    @(negedge clk);
    check(line_o == 1'b1, "R1 line high after mid-frame reset", line_o, 1);
    check(in_ready == 1'b1, "R1 ready high after mid-frame reset", in_ready, 1);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    send(8'h69, 2, 2'b01, 1'b1, 1'b1, 0, "R1 R4 frame after reset");
    wait_idle();
    repeat (10) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R2 run did not finish actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule